// File: doc/BRIEF.md
# Timer Burst Window Register Redirector

This block is the register-file front end of a peripheral timer. It lets a DMA engine move a run of consecutive timer registers through a single bus address. A burst control register holds two fields. The first is a base offset, counted in registers from the first register of the timer's bank. The second is a burst length code. The window register does not store anything itself. A read or write to the window is redirected to the bank register at base offset plus a running burst index. The index moves on by one with every window access. After the programmed number of transfers it starts again from zero.

The bus carries 16-bit words with two byte enables, so a transfer can be a half-word or a single byte. The bus uses a word address, bits 7:2 of `bus_addr`, and decodes it as follows:
- Word 18 (byte offset 0x48) is the burst control register.
- Word 19 (byte offset 0x4C) is the window.
- Every other word below 32 reaches the matching generic bank register directly.
- Words from 32 upward read as zero and ignore writes.

Bank slots 18 and 19 exist, but they can only be reached through the window. Read data is registered. It appears on `bus_rdata` in the cycle after the access and holds until the next read.

Top module: `timer_burst_regfile`

## Requirements
- R1: After a synchronous active-low reset, the control register, all bank registers and the burst index are zero, so both the control register and the window read 0x0000.
- R2: The control register keeps the length code in bits 12:8 and the base offset in bits 4:0. Bits 15:13 and 7:5 always read as zero, whatever was written to them.
- R3: A window access reaches bank register number (base offset + burst index). Reads return its value and writes update it.
- R4: Each window access, read or write, advances the burst index by one.
- R5: A length code of n gives n+1 transfers. The access made at index n is followed by index 0, so code 0 repeats one register and code 17 runs over 18 registers.
- R6: Any write to the control register clears the burst index to zero.
- R7: When base offset + burst index is 32 or more, a window read returns 0x0000 and a window write changes no register, but the index still advances.
- R8: Byte enable bit 0 guards bits 7:0 and bit 1 guards bits 15:8. This holds for direct, window and control writes. Lanes that are not enabled keep their value.
- R9: A direct access to a word below 32, other than words 18 and 19, reaches the bank register of that number. Words 32 and above read as zero.
- R10: Read data appears on `bus_rdata` in the cycle after the read access and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 8 | Byte address; bits 7:2 select the word |
| bus_be | input | 2 | Byte enables for writes |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |

## Verification
The burst index has no port of its own. A wrong index shows up on the very next window access: a read returns a neighbouring register's value, or a write lands in the wrong slot. A later direct read of that slot exposes the misplaced write. A wrong wrap point or a missed clear on a control write therefore shows within one or two accesses, as a value from an unexpected register. Lane and range faults show on the next direct read of the register involved.

// File: rtl/tbr_pkg.sv
// Package: shared constants and helpers for the burst redirector.
// Assumes 16-bit data words and 5-bit length/base fields.
package tbr_pkg;
    localparam int DATA_W   = 16;
    localparam int FIELD_W  = 5;
    localparam int LEN_LSB  = 8;
    localparam int BASE_LSB = 0;

    // Merge new data into old data under byte enables.
    function automatic logic [DATA_W-1:0] lane_merge(
        input logic [DATA_W-1:0] old_v,
        input logic [DATA_W-1:0] new_v,
        input logic [1:0]        be
    );
        logic [DATA_W-1:0] r;
        r[7:0]  = be[0] ? new_v[7:0]  : old_v[7:0];
        r[15:8] = be[1] ? new_v[15:8] : old_v[15:8];
        return r;
    endfunction
endpackage

// File: rtl/tbr_ctrl_reg.sv
// Module: burst control register and running burst index.
// Holds the length code and base offset; the index advances on each
// window access, wraps after index == length and clears on control writes.
// Assumes at most one access per cycle.
module tbr_ctrl_reg
    import tbr_pkg::*;
#(
    parameter int IDX_W = FIELD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic [1:0]        be,
    input  logic [DATA_W-1:0] wdata,
    input  logic              win_access,
    output logic [IDX_W-1:0]  len_code,
    output logic [IDX_W-1:0]  base_off,
    output logic [IDX_W-1:0]  idx,
    output logic [DATA_W-1:0] ctrl_rdata
);
    // Update the fields under byte enables on control writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_code <= '0;
            base_off <= '0;
        end else if (ctrl_we) begin
            if (be[1]) len_code <= wdata[LEN_LSB +: IDX_W];
            if (be[0]) base_off <= wdata[BASE_LSB +: IDX_W];
        end
    end

    // Step the burst index, wrapping at the length code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (ctrl_we) begin
            idx <= '0;
        end else if (win_access) begin
            idx <= (idx == len_code) ? '0 : idx + 1'b1;
        end
    end

    // Assemble the read view; reserved bits stay zero.
    always_comb begin
        ctrl_rdata = '0;
        ctrl_rdata[LEN_LSB +: IDX_W]  = len_code;
        ctrl_rdata[BASE_LSB +: IDX_W] = base_off;
    end

    assert_index_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> idx <= len_code || $past(ctrl_we && !be[1]) == 1'b0);
    assert_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
        win_access && !ctrl_we && idx != len_code |=> idx == $past(idx) + 1'b1);
    assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        win_access && !ctrl_we && idx == len_code |=> idx == '0);
    assert_clear_on_ctrl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_we |=> idx == '0);
endmodule

// File: rtl/tbr_addr_map.sv
// Module: bus decode and redirect target computation.
// Splits an access into control, window or direct bank access and
// flags bank targets at or beyond NUM_REGS as unimplemented.
module tbr_addr_map
    import tbr_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int IDX_W     = FIELD_W,
    parameter int NUM_REGS  = 32,
    parameter int CTRL_WORD = 18,
    parameter int WIN_WORD  = 19,
    localparam int WORD_W   = ADDR_W - 2,
    localparam int TGT_W    = (WORD_W > IDX_W + 1) ? WORD_W : IDX_W + 1
) (
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [IDX_W-1:0]  base_off,
    input  logic [IDX_W-1:0]  idx,
    output logic              is_ctrl,
    output logic              ctrl_we,
    output logic              win_access,
    output logic              bank_hit,
    output logic              bank_we,
    output logic [TGT_W-1:0]  bank_idx
);
    logic [TGT_W-1:0] word;
    logic [TGT_W-1:0] redirect;

    // Classify the access and pick the bank slot it reaches.
    always_comb begin
        word       = TGT_W'(addr[ADDR_W-1:2]);
        redirect   = TGT_W'(base_off) + TGT_W'(idx);
        is_ctrl    = sel && (word == TGT_W'(CTRL_WORD));
        ctrl_we    = is_ctrl && wr;
        win_access = sel && (word == TGT_W'(WIN_WORD));
        bank_idx   = win_access ? redirect : word;
        bank_hit   = sel && !is_ctrl && (bank_idx < TGT_W'(NUM_REGS));
        bank_we    = bank_hit && wr;
    end
endmodule

// File: rtl/tbr_reg_bank.sv
// Module: generic register bank with per-byte write enables.
// One write port; all registers are exposed flat for the read mux.
module tbr_reg_bank
    import tbr_pkg::*;
#(
    parameter int NUM_REGS = 32,
    parameter int TGT_W    = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [TGT_W-1:0]           widx,
    input  logic [1:0]                 be,
    input  logic [DATA_W-1:0]          wdata,
    output logic [NUM_REGS*DATA_W-1:0] regs_flat
);
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic [DATA_W-1:0] q;
        logic              hit;
        assign hit = we && (widx == TGT_W'(g));

        // Store one register, merging only the enabled lanes.
        always_ff @(posedge clk) begin
            if (!rst_n)   q <= '0;
            else if (hit) q <= lane_merge(q, wdata, be);
        end
        assign regs_flat[g*DATA_W +: DATA_W] = q;

        assert_lane_low_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
            hit && !be[0] |=> $stable(regs_flat[g*DATA_W +: 8]));
        assert_lane_high_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
            hit && !be[1] |=> $stable(regs_flat[g*DATA_W + 8 +: 8]));
    end
endmodule

// File: rtl/timer_burst_regfile.sv
// Module: top of the burst window redirector.
// Decodes the bus, holds the burst control register, forwards window
// accesses to base+index in the bank, and registers read data.
// Assumes one access per cycle on a synchronous bus.
module timer_burst_regfile
    import tbr_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int NUM_REGS  = 32,
    parameter int CTRL_WORD = 18,
    parameter int WIN_WORD  = 19,
    localparam int IDX_W    = FIELD_W,
    localparam int WORD_W   = ADDR_W - 2,
    localparam int TGT_W    = (WORD_W > IDX_W + 1) ? WORD_W : IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_be,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);
    logic [IDX_W-1:0]           len_code, base_off, idx;
    logic [DATA_W-1:0]          ctrl_rdata;
    logic                       is_ctrl, ctrl_we, win_access, bank_hit, bank_we;
    logic [TGT_W-1:0]           bank_idx;
    logic [NUM_REGS*DATA_W-1:0] regs_flat;
    logic [DATA_W-1:0]          rd_value;

    tbr_ctrl_reg #(.IDX_W(IDX_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .be(bus_be),
        .wdata(bus_wdata), .win_access(win_access), .len_code(len_code),
        .base_off(base_off), .idx(idx), .ctrl_rdata(ctrl_rdata)
    );

    tbr_addr_map #(
        .ADDR_W(ADDR_W), .IDX_W(IDX_W), .NUM_REGS(NUM_REGS),
        .CTRL_WORD(CTRL_WORD), .WIN_WORD(WIN_WORD)
    ) u_map (
        .sel(bus_sel), .wr(bus_wr), .addr(bus_addr), .base_off(base_off),
        .idx(idx), .is_ctrl(is_ctrl), .ctrl_we(ctrl_we),
        .win_access(win_access), .bank_hit(bank_hit), .bank_we(bank_we),
        .bank_idx(bank_idx)
    );

    tbr_reg_bank #(.NUM_REGS(NUM_REGS), .TGT_W(TGT_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .we(bank_we), .widx(bank_idx),
        .be(bus_be), .wdata(bus_wdata), .regs_flat(regs_flat)
    );

    // Select the value an access would read; unimplemented slots give zero.
    always_comb begin
        rd_value = '0;
        if (is_ctrl) begin
            rd_value = ctrl_rdata;
        end else if (bank_hit) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                if (bank_idx == TGT_W'(i)) rd_value = regs_flat[i*DATA_W +: DATA_W];
            end
        end
    end

    // Capture read data one cycle after a read access and hold it.
    always_ff @(posedge clk) begin
        if (!rst_n)                 bus_rdata <= '0;
        else if (bus_sel && !bus_wr) bus_rdata <= rd_value;
    end

    assert_ctrl_reserved_R2: assert property (@(posedge clk) disable iff (!rst_n)
        is_ctrl && !bus_wr |=> bus_rdata[15:13] == 3'b0 && bus_rdata[7:5] == 3'b0);
    assert_oob_write_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        win_access && bus_wr && !bank_hit |=> $stable(regs_flat));
    assert_oob_read_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        win_access && !bus_wr && !bank_hit |=> bus_rdata == '0);
    assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && !bus_wr) |=> $stable(bus_rdata));
endmodule

// File: tb/tb_timer_burst_regfile.sv
`timescale 1ns/1ps
module tb_timer_burst_regfile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [1:0]  bus_be = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;

    int errors = 0;
    int checks = 0;

    // Reference state built from the requirements.
    logic [15:0] mbank [32];
    logic [4:0]  mlen, mbase, midx;

    always #4 clk = ~clk;

    timer_burst_regfile dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata)
    );

    function automatic logic [15:0] merge(input logic [15:0] o, input logic [15:0] n,
                                          input logic [1:0] be);
        return {be[1] ? n[15:8] : o[15:8], be[0] ? n[7:0] : o[7:0]};
    endfunction

    function automatic logic [15:0] model_read(input int word);
        int t;
        if (word == 18) return {3'b0, mlen, 3'b0, mbase};
        if (word == 19) begin
            t = int'(mbase) + int'(midx);
            return (t < 32) ? mbank[t] : 16'h0;
        end
        return (word < 32) ? mbank[word] : 16'h0;
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_update(input bit wr, input int word, input logic [1:0] be,
                                input logic [15:0] d);
        int t;
        if (word == 18) begin
            if (wr) begin
                if (be[1]) mlen = d[12:8];
                if (be[0]) mbase = d[4:0];
                midx = '0;
            end
        end else if (word == 19) begin
            t = int'(mbase) + int'(midx);
            if (wr && t < 32) mbank[t] = merge(mbank[t], d, be);
            midx = (midx == mlen) ? 5'd0 : midx + 5'd1;
        end else if (wr && word < 32) begin
            mbank[word] = merge(mbank[word], d, be);
        end
    endtask

    // One bus access; a read is compared with the model value.
    task automatic acc(input bit wr, input int word, input logic [1:0] be,
                       input logic [15:0] d, input string tag);
        logic [15:0] exp;
        exp = model_read(word);
        model_update(wr, word, be, d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = wr; bus_addr = 8'(word << 2);
        bus_be = be; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        if (!wr) check(tag, bus_rdata, exp);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) mbank[i] = '0;
        mlen = '0; mbase = '0; midx = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        acc(0, 18, 2'b11, 0, "R1 ctrl reset");
        acc(0, 19, 2'b11, 0, "R1 window reset");
        acc(0, 5, 2'b11, 0, "R1 bank reset");

        // R2: reserved bits dropped, fields kept
        acc(1, 18, 2'b11, 16'hFFFF, "R2");
        acc(0, 18, 2'b11, 0, "R2 reserved zero");
        check("R2 value", bus_rdata, 16'h1F1F);

        // R3/R4/R5: base 4, code 2 -> slots 4,5,6 then wrap to 4
        acc(1, 18, 2'b11, 16'h0204, "R6");
        acc(1, 19, 2'b11, 16'hA004, "R3");
        acc(1, 19, 2'b11, 16'hA005, "R4");
        acc(1, 19, 2'b11, 16'hA006, "R4");
        acc(1, 19, 2'b11, 16'hB004, "R5 wrap");
        acc(0, 4, 2'b11, 0, "R5 slot4");
        acc(0, 5, 2'b11, 0, "R3 slot5");
        acc(0, 6, 2'b11, 0, "R3 slot6");
        acc(0, 7, 2'b11, 0, "R5 slot7 untouched");

        // R6: control write mid-burst clears index
        acc(0, 19, 2'b11, 0, "R6 pre");
        acc(1, 18, 2'b11, 16'h0204, "R6");
        acc(0, 19, 2'b11, 0, "R6 restart at base");

        // R5: code 0 repeats one register; code 17 spans 18
        acc(1, 18, 2'b11, 16'h000A, "R5");
        acc(1, 19, 2'b11, 16'h1111, "R5 len0");
        acc(1, 19, 2'b11, 16'h2222, "R5 len0");
        acc(0, 10, 2'b11, 0, "R5 len0 same slot");
        acc(0, 11, 2'b11, 0, "R5 len0 next slot");
        acc(1, 18, 2'b11, 16'h1100, "R5");
        for (int i = 0; i < 18; i++) acc(1, 19, 2'b11, 16'(16'h3000 + i), "R5");
        acc(0, 19, 2'b11, 0, "R5 len17 wrap");
        acc(0, 17, 2'b11, 0, "R5 len17 last");

        // R7: base 30, code 3 -> 30,31,oob,oob
        acc(1, 18, 2'b11, 16'h031E, "R7");
        acc(1, 19, 2'b11, 16'h5555, "R7");
        acc(1, 19, 2'b11, 16'h6666, "R7");
        acc(1, 19, 2'b11, 16'h7777, "R7 oob write");
        acc(0, 19, 2'b11, 0, "R7 oob read");
        acc(0, 19, 2'b11, 0, "R7 wrapped");
        acc(0, 0, 2'b11, 0, "R7 slot0 untouched");

        // R8: byte lanes, direct and window
        acc(1, 2, 2'b11, 16'hABCD, "R8");
        acc(1, 2, 2'b01, 16'h1234, "R8");
        acc(0, 2, 2'b11, 0, "R8 low lane");
        acc(1, 18, 2'b01, 16'hFF02, "R8");
        acc(0, 18, 2'b11, 0, "R8 ctrl low lane");
        acc(1, 19, 2'b10, 16'h9988, "R8");
        acc(0, 2, 2'b11, 0, "R8 high lane window");

        // R9: high words read zero
        acc(1, 40, 2'b11, 16'hFFFF, "R9");
        acc(0, 40, 2'b11, 0, "R9 unmapped");

        // Random mix against the model (R3, R4, R9, R10)
        void'($urandom(32'd1234));
        for (int n = 0; n < 600; n++) begin
            int w;
            int sel = $urandom_range(0, 9);
            w = (sel < 4) ? 19 : (sel < 5) ? 18 : $urandom_range(0, 35);
            acc($urandom_range(0, 1), w, 2'($urandom_range(1, 3)),
                16'($urandom), "R3 R9 random");
        end
        // R10: data holds across idle cycles
        acc(0, 2, 2'b11, 0, "R10");
        repeat (3) @(negedge clk);
        check("R10 hold", bus_rdata, mbank[2]);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule